// File: doc/BRIEF.md
# Split Loadable Up-Counter with Registered Carry

This block is a 31-bit binary up-counter that can also be loaded in parallel. The counter is split into two sections: a 15-bit low section and a 16-bit high section. A single carry flip-flop links them. The carry is predicted one cycle early from the low bits, or from the load word during a load. The high section therefore steps on a registered signal. It never decodes the whole low section in the same cycle.

The result is that every path runs from one register to the next. No combinational path crosses both sections, so the counter runs at a single register-to-register clock period. A synchronous load takes priority over counting. A count enable freezes the whole state while it is low. An output enable gates the visible count, which is presented as a valid flag plus a data word.

Top module: `split_counter`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, the count is 0. With out_en_i high, cnt_o reads 0.
- R2: When load_i is high at a rising edge, the count after that edge equals data_i.
- R3: The high section (count bits 30..15) advances only at the edge where the low section (bits 14..0) wraps from 0x7FFF to 0. This holds when the low bits reach 0x7FFF by counting and when they are loaded as 0x7FFF. A later load clears a pending carry.
- R4: When load_i is low and cnt_en_i is high at a rising edge, the count advances by exactly 1, modulo 2^31.
- R5: When load_i and cnt_en_i are both high, the load wins, and the count becomes data_i, not data_i+1.
- R6: When load_i and cnt_en_i are both low, the count and the pending carry hold. This includes a hold while the low bits sit at 0x7FFF.
- R7: cnt_valid_o follows out_en_i. While out_en_i is low, cnt_o is 0, but the internal count keeps advancing.
- R8: From 0x7FFFFFFF, one count step gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Synchronous parallel load |
| data_i | input | 31 | Load value |
| cnt_en_i | input | 1 | Count enable |
| out_en_i | input | 1 | Output enable |
| cnt_o | output | 31 | Count value, 0 while disabled |
| cnt_valid_o | output | 1 | High when cnt_o is driven |

## Verification
The assertions assume that load_i, cnt_en_i, out_en_i and data_i are stable and known at every rising edge once reset is released. They also assume that reset is applied before any other activity. The bench drives all inputs only on falling edges from its tasks. It holds reset for several cycles and keeps every control at a defined level. It compares the count against a plain 31-bit reference counter, sampled 1 ns after each rising edge. Its loads sit just below, at and just after the low-section wrap point.

// File: rtl/split_cnt_pkg.sv
package split_cnt_pkg;
  parameter int unsigned CNT_W_DEF = 31;
  parameter int unsigned LO_W_DEF  = 15;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } cnt_op_e;

  function automatic cnt_op_e decode_op(input logic load, input logic en);
    if (load)    return OP_LOAD;
    else if (en) return OP_COUNT;
    else         return OP_HOLD;
  endfunction
endpackage

// File: rtl/cnt_section.sv
module cnt_section #(
  parameter int unsigned W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         inc_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (load_i) q <= d_i;
    else if (inc_i)  q <= q + W'(1);
  end

  assign q_o = q;
endmodule

// File: rtl/carry_pred.sv
module carry_pred #(
  parameter int unsigned W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         inc_i,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] lo_i,
  output logic         carry_o
);
  logic carry_q, near_top, load_top;

  // low section one step short of all ones
  generate
    if (W == 1) begin : g_w1
      assign near_top = ~lo_i[0];
    end else begin : g_wn
      assign near_top = (&lo_i[W-1:1]) & ~lo_i[0];
    end
  endgenerate

  assign load_top = &d_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     carry_q <= 1'b0;
    else if (load_i) carry_q <= load_top;
    else if (inc_i)  carry_q <= near_top;
  end

  assign carry_o = carry_q;
endmodule

// File: rtl/split_counter.sv
module split_counter
  import split_cnt_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned LO_W  = LO_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             cnt_en_i,
  input  logic             out_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cnt_valid_o
);
  localparam int unsigned HI_W = CNT_W - LO_W;

  cnt_op_e         op;
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic            carry_q;
  logic            do_load, do_inc, hi_inc;

  assign op      = decode_op(load_i, cnt_en_i);
  assign do_load = (op == OP_LOAD);
  assign do_inc  = (op == OP_COUNT);
  assign hi_inc  = do_inc & carry_q;

  cnt_section #(.W(LO_W)) u_lo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (do_load),
    .inc_i  (do_inc),
    .d_i    (data_i[LO_W-1:0]),
    .q_o    (lo_q)
  );

  cnt_section #(.W(HI_W)) u_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (do_load),
    .inc_i  (hi_inc),
    .d_i    (data_i[CNT_W-1:LO_W]),
    .q_o    (hi_q)
  );

  carry_pred #(.W(LO_W)) u_carry (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (do_load),
    .inc_i   (do_inc),
    .d_i     (data_i[LO_W-1:0]),
    .lo_i    (lo_q),
    .carry_o (carry_q)
  );

  assign cnt_valid_o = out_en_i;
  assign cnt_o       = out_en_i ? {hi_q, lo_q} : '0;
endmodule

// File: rtl/split_counter_chk.sv
module split_counter_chk #(
  parameter int unsigned CNT_W = 31,
  parameter int unsigned LO_W  = 15
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  load_i,
  input logic [CNT_W-1:0]      data_i,
  input logic                  cnt_en_i,
  input logic                  out_en_i,
  input logic [CNT_W-1:0]      cnt_o,
  input logic                  cnt_valid_o,
  input logic [LO_W-1:0]       lo_q,
  input logic [CNT_W-LO_W-1:0] hi_q,
  input logic                  carry_q
);
  logic [CNT_W-1:0] full;
  assign full = {hi_q, lo_q};

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (full == $past(data_i)));

  assert_carry_track_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_q == (&lo_q));

  assert_hi_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_en_i && !(&lo_q)) |=> $stable(hi_q));

  assert_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_en_i) |=> (full == $past(full) + CNT_W'(1)));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !cnt_en_i) |=> ($stable(full) && $stable(carry_q)));

  assert_oe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |-> (cnt_o == '0 && !cnt_valid_o));
endmodule

bind split_counter split_counter_chk #(.CNT_W(CNT_W), .LO_W(LO_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_i      (load_i),
  .data_i      (data_i),
  .cnt_en_i    (cnt_en_i),
  .out_en_i    (out_en_i),
  .cnt_o       (cnt_o),
  .cnt_valid_o (cnt_valid_o),
  .lo_q        (lo_q),
  .hi_q        (hi_q),
  .carry_q     (carry_q)
);

// File: tb/split_counter_bench.sv
`timescale 1ns/1ps
module split_counter_bench;
  localparam int W = 31;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld = 1'b0, en = 1'b0, oe = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] cnt;
  logic         vld;
  logic [W-1:0] ref_q = '0;
  int           n_run = 0, n_fail = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  split_counter u_split_counter (
    .clk_i(clk), .rst_ni(rst_n), .load_i(ld), .data_i(din),
    .cnt_en_i(en), .out_en_i(oe), .cnt_o(cnt), .cnt_valid_o(vld)
  );

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one clock: drive at falling edge, update reference at rising edge, sample 1 ns later
  task automatic step(input logic l, input logic [W-1:0] d, input logic e);
    @(negedge clk);
    ld = l; din = d; en = e;
    @(posedge clk);
    if (l) ref_q = d;
    else if (e) ref_q = ref_q + W'(1);
    #1;
  endtask

  task automatic t_reset();
    chk("R1 reset count", cnt, '0);
    chk("R1 reset valid", {30'd0, vld}, 31'd1);
  endtask

  task automatic t_load();
    step(1'b1, 31'h1234_5678, 1'b0);
    chk("R2 load", cnt, 31'h1234_5678);
    step(1'b1, 31'h0000_0005, 1'b0);
    chk("R2 reload", cnt, 31'h5);
  endtask

  task automatic t_count_plain();
    for (int i = 0; i < 20; i++) begin
      step(1'b0, '0, 1'b1);
      chk("R4 plain count", cnt, ref_q);
    end
  endtask

  task automatic t_low_wrap();
    step(1'b1, {16'h0003, 15'h7FF0}, 1'b0);
    for (int i = 0; i < 40; i++) begin
      step(1'b0, '0, 1'b1);
      chk("R3 R4 low wrap", cnt, ref_q);
    end
  endtask

  task automatic t_load_edge();
    step(1'b1, {16'h0005, 15'h7FFF}, 1'b0);
    step(1'b0, '0, 1'b1);
    chk("R3 loaded 7FFF carries", cnt, {16'h0006, 15'h0000});
    step(1'b1, {16'h0009, 15'h7FFE}, 1'b0);
    step(1'b0, '0, 1'b1);
    chk("R3 7FFE no early carry", cnt, {16'h0009, 15'h7FFF});
    step(1'b0, '0, 1'b1);
    chk("R3 carry after predict", cnt, {16'h000A, 15'h0000});
    // pending carry must be cleared by a later load
    step(1'b1, {16'h0002, 15'h7FFF}, 1'b0);
    step(1'b1, {16'h0002, 15'h0000}, 1'b0);
    step(1'b0, '0, 1'b1);
    chk("R3 load clears carry", cnt, {16'h0002, 15'h0001});
  endtask

  task automatic t_priority();
    step(1'b1, 31'h0000_0100, 1'b1);
    chk("R5 load over count", cnt, 31'h100);
    step(1'b1, {16'h0001, 15'h7FFF}, 1'b1);
    chk("R5 load over count at wrap", cnt, {16'h0001, 15'h7FFF});
  endtask

  task automatic t_hold();
    step(1'b1, {16'h00AA, 15'h7FFF}, 1'b0);
    for (int i = 0; i < 5; i++) begin
      step(1'b0, '0, 1'b0);
      chk("R6 hold", cnt, {16'h00AA, 15'h7FFF});
    end
    step(1'b0, '0, 1'b1);
    chk("R6 carry kept over hold", cnt, {16'h00AB, 15'h0000});
  endtask

  task automatic t_oe();
    step(1'b1, 31'h0000_0040, 1'b0);
    @(negedge clk); oe = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step(1'b0, '0, 1'b1);
      chk("R7 disabled data", cnt, '0);
      chk("R7 disabled valid", {30'd0, vld}, '0);
    end
    @(negedge clk); oe = 1'b1; #1;
    chk("R7 enabled again", cnt, 31'h43);
    chk("R7 ref agrees", cnt, ref_q);
  endtask

  task automatic t_full_wrap();
    step(1'b1, 31'h7FFF_FFFD, 1'b0);
    for (int i = 0; i < 5; i++) begin
      step(1'b0, '0, 1'b1);
      chk("R8 full wrap", cnt, ref_q);
    end
    chk("R8 end value", cnt, 31'h2);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    chk("R1 in reset", cnt, '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_load();
    t_count_plain();
    t_low_wrap();
    t_load_edge();
    t_priority();
    t_hold();
    t_oe();
    t_full_wrap();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule